// File: doc/BRIEF.md
# Pointer Load/Store Address Unit

This unit forms data-memory addresses for the load, store, push and pop operations of an 8-bit processor core. It holds four 16-bit address registers: three general pointers (X, Y, Z) and a stack pointer. Each accepted request names an addressing mode, a pointer, a 6-bit displacement, a direct address and a store operand. The unit issues one access on a synchronous data-memory port and updates the selected pointer. Load data comes back on a register-file write port.

Operations that complete in one cycle issue their access in the cycle the request is accepted. Operations that take two cycles update any pointer at the acceptance edge and raise `busy_o` during the following cycle. The access happens in that following cycle, and new requests are not taken while `busy_o` is high. No operation produces status flags.

Top module: `ldst_addr_unit`

## Requirements
- R1: After reset all four pointers read zero, `busy_o`, `mem_en_o` and `rd_we_o` are low.
- R2: With `ptr_we_i` high, the register selected by `ptr_wsel_i` (0 = X, 1 = Y, 2 = Z, 3 = SP) takes `ptr_wdata_i` at the clock edge. If a pointer update from an accepted operation targets the same register at the same edge, the operation's value is kept.
- R3: Mode 0 (plain indirect, `ptr_sel_i` 0 = X, 1 = Y, 2 = Z) accesses memory at the pointer in the accepting cycle and leaves the pointer unchanged. `store_i` = 1 makes it a write (`mem_we_o` = 1), otherwise it is a read.
- R4: Mode 1 (post-increment) accesses memory at the current pointer in the accepting cycle, and the pointer becomes pointer+1 modulo 2^16 at that edge.
- R5: Mode 2 (pre-decrement) sets the pointer to pointer-1 modulo 2^16 at the accepting edge. In the next cycle, with `busy_o` high, it accesses memory at that decremented address.
- R6: Mode 3 (displacement) is allowed for Y and Z only. In the cycle after acceptance it accesses pointer + zero-extended `disp_i` (0 to 63) modulo 2^16 and does not change the pointer. With X selected the request is dropped: no access, no pointer change, no busy cycle.
- R7: Mode 4 (direct store) writes `wdata_i` to `dir_addr_i` in the cycle after acceptance.
- R8: Mode 5 (push) writes `wdata_i` at SP in the accepting cycle, and SP becomes SP-1 at that edge.
- R9: Mode 6 (pop) sets SP to SP+1 at the accepting edge and reads memory at the new SP in the next cycle.
- R10: `rd_we_o` is high for exactly the cycle after each read access, with `rd_data_o` equal to the synchronous memory's returned byte.
- R11: `busy_o` is high only in the second cycle of a two-cycle operation. A request presented while `busy_o` is high causes no access and no pointer change of its own.
- R12: A request with `ptr_sel_i` = 3 in modes 0 to 3, or with mode 7, is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Operation request |
| mode_i | input | 3 | Addressing mode (0 to 7) |
| ptr_sel_i | input | 2 | Pointer select: 0 X, 1 Y, 2 Z |
| store_i | input | 1 | Write for modes 0 to 3 |
| disp_i | input | QW (6) | Unsigned displacement |
| dir_addr_i | input | AW (16) | Direct store address |
| wdata_i | input | DW (8) | Store operand |
| ptr_we_i | input | 1 | Pointer load enable |
| ptr_wsel_i | input | 2 | Pointer load target: 0 X, 1 Y, 2 Z, 3 SP |
| ptr_wdata_i | input | AW (16) | Pointer load value |
| busy_o | output | 1 | Second cycle of a two-cycle operation |
| mem_en_o | output | 1 | Memory access enable |
| mem_we_o | output | 1 | Memory write (1) or read (0) |
| mem_addr_o | output | AW (16) | Memory address |
| mem_wdata_o | output | DW (8) | Memory write data |
| mem_rdata_i | input | DW (8) | Memory read data, one cycle after the read |
| rd_we_o | output | 1 | Load-data write strobe |
| rd_data_o | output | DW (8) | Load data |
| ptr_x_o | output | AW (16) | X pointer |
| ptr_y_o | output | AW (16) | Y pointer |
| ptr_z_o | output | AW (16) | Z pointer |
| sp_o | output | AW (16) | Stack pointer |

## Verification
The hardest situation to reach from the ports is a request that arrives during the busy cycle while the pending access uses an address latched from a pointer that has already moved. The stimulus holds a pre-decrement request on `req_i` and keeps a post-increment request on the same pointer asserted through the busy cycle. The bench then checks that neither the pointer nor the memory port reacts to the second request. Wrap cases at 0x0000 and 0xFFFF are reached by loading pointers through the pointer load port. A pointer load that collides with a post-increment on the same register is also driven, so the precedence rule is exercised.

// File: rtl/ldst_pkg.sv
package ldst_pkg;
  typedef enum logic [2:0] {
    M_IND     = 3'd0,
    M_POSTINC = 3'd1,
    M_PREDEC  = 3'd2,
    M_DISP    = 3'd3,
    M_DIRECT  = 3'd4,
    M_PUSH    = 3'd5,
    M_POP     = 3'd6,
    M_RSVD    = 3'd7
  } mode_e;

  localparam int unsigned NPTR = 4;
  localparam int unsigned SW   = $clog2(NPTR);
  localparam logic [SW-1:0] SEL_X  = 2'd0;
  localparam logic [SW-1:0] SEL_Y  = 2'd1;
  localparam logic [SW-1:0] SEL_Z  = 2'd2;
  localparam logic [SW-1:0] SEL_SP = 2'd3;
endpackage

// File: rtl/ldst_ptr_file.sv
module ldst_ptr_file
  import ldst_pkg::*;
#(
  parameter int unsigned AW = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     ext_we_i,
  input  logic [SW-1:0]            ext_sel_i,
  input  logic [AW-1:0]            ext_data_i,
  input  logic                     upd_we_i,
  input  logic [SW-1:0]            upd_sel_i,
  input  logic [AW-1:0]            upd_data_i,
  output logic [NPTR-1:0][AW-1:0]  ptr_o
);
  for (genvar g = 0; g < NPTR; g++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  ptr_o[g] <= '0;
      else if (upd_we_i && upd_sel_i == SW'(g))     ptr_o[g] <= upd_data_i;
      else if (ext_we_i && ext_sel_i == SW'(g))     ptr_o[g] <= ext_data_i;
    end
  end
endmodule

// File: rtl/ldst_addr_calc.sv
module ldst_addr_calc
  import ldst_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned QW = 6
) (
  input  mode_e                    mode_i,
  input  logic [SW-1:0]            sel_i,
  input  logic                     store_i,
  input  logic [QW-1:0]            disp_i,
  input  logic [AW-1:0]            dir_addr_i,
  input  logic [NPTR-1:0][AW-1:0]  ptr_i,
  output logic                     ok_o,
  output logic                     two_o,
  output logic                     we_o,
  output logic [AW-1:0]            addr_o,
  output logic                     upd_o,
  output logic [SW-1:0]            upd_sel_o,
  output logic [AW-1:0]            upd_val_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  logic [AW-1:0] base, sp, base_inc, base_dec;
  logic          gp_sel;

  assign base     = ptr_i[sel_i];
  assign sp       = ptr_i[SEL_SP];
  assign base_inc = base + ONE;
  assign base_dec = base - ONE;
  assign gp_sel   = (sel_i != SEL_SP);

  always_comb begin
    ok_o      = 1'b0;
    two_o     = 1'b0;
    we_o      = store_i;
    addr_o    = base;
    upd_o     = 1'b0;
    upd_sel_o = sel_i;
    upd_val_o = base_inc;
    unique case (mode_i)
      M_IND:     ok_o = gp_sel;
      M_POSTINC: begin ok_o = gp_sel; upd_o = 1'b1; end
      M_PREDEC: begin
        ok_o = gp_sel; two_o = 1'b1; addr_o = base_dec;
        upd_o = 1'b1; upd_val_o = base_dec;
      end
      M_DISP: begin
        ok_o   = (sel_i == SEL_Y) || (sel_i == SEL_Z);
        two_o  = 1'b1;
        addr_o = base + {{(AW-QW){1'b0}}, disp_i};
      end
      M_DIRECT: begin ok_o = 1'b1; two_o = 1'b1; we_o = 1'b1; addr_o = dir_addr_i; end
      M_PUSH: begin
        ok_o = 1'b1; we_o = 1'b1; addr_o = sp;
        upd_o = 1'b1; upd_sel_o = SEL_SP; upd_val_o = sp - ONE;
      end
      M_POP: begin
        ok_o = 1'b1; two_o = 1'b1; we_o = 1'b0; addr_o = sp + ONE;
        upd_o = 1'b1; upd_sel_o = SEL_SP; upd_val_o = sp + ONE;
      end
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/ldst_seq.sv
module ldst_seq #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          ok_i,
  input  logic          two_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          accept_o,
  output logic          busy_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          rd_we_o
);
  logic          busy_q, we_q, ld_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  assign busy_o   = busy_q;
  assign accept_o = req_i && ok_i && !busy_q;
  assign rd_we_o  = ld_q;

  always_comb begin
    if (busy_q) begin
      mem_en_o    = 1'b1;
      mem_we_o    = we_q;
      mem_addr_o  = addr_q;
      mem_wdata_o = wdata_q;
    end else begin
      mem_en_o    = accept_o && !two_i;
      mem_we_o    = we_i;
      mem_addr_o  = addr_i;
      mem_wdata_o = wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      we_q    <= 1'b0;
      ld_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      busy_q <= accept_o && two_i;
      ld_q   <= mem_en_o && !mem_we_o;
      // second-cycle access uses address formed at acceptance
      if (accept_o && two_i) begin
        we_q    <= we_i;
        addr_q  <= addr_i;
        wdata_q <= wdata_i;
      end
    end
  end
endmodule

// File: rtl/ldst_addr_unit.sv
module ldst_addr_unit
  import ldst_pkg::*;
#(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8,
  parameter int unsigned QW = 6
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic [2:0]    mode_i,
  input  logic [1:0]    ptr_sel_i,
  input  logic          store_i,
  input  logic [QW-1:0] disp_i,
  input  logic [AW-1:0] dir_addr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          ptr_we_i,
  input  logic [1:0]    ptr_wsel_i,
  input  logic [AW-1:0] ptr_wdata_i,
  output logic          busy_o,
  output logic          mem_en_o,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic          rd_we_o,
  output logic [DW-1:0] rd_data_o,
  output logic [AW-1:0] ptr_x_o,
  output logic [AW-1:0] ptr_y_o,
  output logic [AW-1:0] ptr_z_o,
  output logic [AW-1:0] sp_o
);
  logic [NPTR-1:0][AW-1:0] ptrs;
  logic                    ok, two, we, upd, accept;
  logic [AW-1:0]           addr, upd_val;
  logic [SW-1:0]           upd_sel;

  ldst_ptr_file #(.AW(AW)) i_ptr_file (
    .clk_i, .rst_ni,
    .ext_we_i   (ptr_we_i),
    .ext_sel_i  (ptr_wsel_i),
    .ext_data_i (ptr_wdata_i),
    .upd_we_i   (accept && upd),
    .upd_sel_i  (upd_sel),
    .upd_data_i (upd_val),
    .ptr_o      (ptrs)
  );

  ldst_addr_calc #(.AW(AW), .QW(QW)) i_addr_calc (
    .mode_i     (mode_e'(mode_i)),
    .sel_i      (ptr_sel_i),
    .store_i,
    .disp_i,
    .dir_addr_i,
    .ptr_i      (ptrs),
    .ok_o       (ok),
    .two_o      (two),
    .we_o       (we),
    .addr_o     (addr),
    .upd_o      (upd),
    .upd_sel_o  (upd_sel),
    .upd_val_o  (upd_val)
  );

  ldst_seq #(.AW(AW), .DW(DW)) i_seq (
    .clk_i, .rst_ni, .req_i,
    .ok_i       (ok),
    .two_i      (two),
    .we_i       (we),
    .addr_i     (addr),
    .wdata_i,
    .accept_o   (accept),
    .busy_o,
    .mem_en_o,
    .mem_we_o,
    .mem_addr_o,
    .mem_wdata_o,
    .rd_we_o
  );

  assign rd_data_o = mem_rdata_i;
  assign ptr_x_o   = ptrs[SEL_X];
  assign ptr_y_o   = ptrs[SEL_Y];
  assign ptr_z_o   = ptrs[SEL_Z];
  assign sp_o      = ptrs[SEL_SP];
endmodule

// File: rtl/ldst_addr_unit_chk.sv
module ldst_addr_unit_chk #(
  parameter int unsigned AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          req_i,
  input logic [2:0]    mode_i,
  input logic [1:0]    ptr_sel_i,
  input logic          ptr_we_i,
  input logic          busy_o,
  input logic          mem_en_o,
  input logic          mem_we_o,
  input logic          rd_we_o,
  input logic [AW-1:0] ptr_x_o,
  input logic [AW-1:0] sp_o
);
  localparam logic [AW-1:0] ONE = AW'(1);

  // R1
  always_comb if (!rst_ni) reset_quiet_chk: assert (!busy_o && !rd_we_o);

  // R11
  busy_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> !busy_o);

  // R11
  busy_access_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> mem_en_o);

  // R11
  busy_hold_x_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && !ptr_we_i |=> ptr_x_o == $past(ptr_x_o));

  // R10
  rd_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_en_o && !mem_we_o |=> rd_we_o);

  // R10
  rd_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> $past(mem_en_o && !mem_we_o));

  // R4
  postinc_x_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o && mode_i == 3'd1 && ptr_sel_i == 2'd0
    |=> ptr_x_o == $past(ptr_x_o) + ONE);

  // R8
  push_sp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && !busy_o && mode_i == 3'd5 |-> mem_en_o && mem_we_o);
endmodule

bind ldst_addr_unit ldst_addr_unit_chk #(.AW(AW)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .mode_i    (mode_i),
  .ptr_sel_i (ptr_sel_i),
  .ptr_we_i  (ptr_we_i),
  .busy_o    (busy_o),
  .mem_en_o  (mem_en_o),
  .mem_we_o  (mem_we_o),
  .rd_we_o   (rd_we_o),
  .ptr_x_o   (ptr_x_o),
  .sp_o      (sp_o)
);

// File: tb/test_ldst_addr_unit.sv
`timescale 1ns/1ps
module test_ldst_addr_unit;
  localparam int AW = 16, DW = 8, QW = 6;

  logic          clk_i = 1'b0, rst_ni = 1'b0;
  logic          req_i = 0, store_i = 0, ptr_we_i = 0;
  logic [2:0]    mode_i = 0;
  logic [1:0]    ptr_sel_i = 0, ptr_wsel_i = 0;
  logic [QW-1:0] disp_i = 0;
  logic [AW-1:0] dir_addr_i = 0, ptr_wdata_i = 0;
  logic [DW-1:0] wdata_i = 0, mem_rdata_i;
  logic          busy_o, mem_en_o, mem_we_o, rd_we_o;
  logic [AW-1:0] mem_addr_o, ptr_x_o, ptr_y_o, ptr_z_o, sp_o;
  logic [DW-1:0] mem_wdata_o, rd_data_o;

  always #10 clk_i = ~clk_i;

  ldst_addr_unit #(.AW(AW), .DW(DW), .QW(QW)) i_ldst_addr_unit (.*);

  // device-side memory
  logic [DW-1:0] dmem [0:65535];
  always @(posedge clk_i) begin
    if (mem_en_o && mem_we_o) dmem[mem_addr_o] <= mem_wdata_o;
    else if (mem_en_o)        mem_rdata_i <= dmem[mem_addr_o];
  end

  // reference model state
  logic [DW-1:0] mmem [0:65535];
  logic [AW-1:0] m_ptr [4];
  logic          m_busy = 0, m_we = 0, m_ldp = 0;
  logic [AW-1:0] m_addr = 0;
  logic [DW-1:0] m_wd = 0, m_ldv = 0;
  int checks = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag);
    logic e_en, e_we, two, upd;
    logic [AW-1:0] e_addr, uval, p;
    logic [DW-1:0] e_wd;
    int usel;
    #1;
    e_en = 0; e_we = 0; e_addr = 0; e_wd = 0; two = 0; upd = 0; uval = 0; usel = 0;
    p = m_ptr[ptr_sel_i];
    if (m_busy) begin
      e_en = 1; e_we = m_we; e_addr = m_addr; e_wd = m_wd;
    end else if (req_i) begin
      case (mode_i)
        3'd0: if (ptr_sel_i != 3) begin e_en = 1; e_addr = p; e_we = store_i; e_wd = wdata_i; end
        3'd1: if (ptr_sel_i != 3) begin
          e_en = 1; e_addr = p; e_we = store_i; e_wd = wdata_i;
          upd = 1; usel = ptr_sel_i; uval = p + 1;
        end
        3'd2: if (ptr_sel_i != 3) begin
          two = 1; e_addr = p - 1; e_we = store_i; e_wd = wdata_i;
          upd = 1; usel = ptr_sel_i; uval = p - 1;
        end
        3'd3: if (ptr_sel_i == 1 || ptr_sel_i == 2) begin
          two = 1; e_addr = p + AW'(disp_i); e_we = store_i; e_wd = wdata_i;
        end
        3'd4: begin two = 1; e_addr = dir_addr_i; e_we = 1; e_wd = wdata_i; end
        3'd5: begin
          e_en = 1; e_addr = m_ptr[3]; e_we = 1; e_wd = wdata_i;
          upd = 1; usel = 3; uval = m_ptr[3] - 1;
        end
        3'd6: begin
          two = 1; e_addr = m_ptr[3] + 1; e_we = 0;
          upd = 1; usel = 3; uval = m_ptr[3] + 1;
        end
        default: ;
      endcase
    end
    chk(mem_en_o === e_en, tag, "mem_en", AW'(mem_en_o), AW'(e_en));
    if (e_en) begin
      chk(mem_we_o === e_we, tag, "mem_we", AW'(mem_we_o), AW'(e_we));
      chk(mem_addr_o === e_addr, tag, "mem_addr", mem_addr_o, e_addr);
      if (e_we) chk(mem_wdata_o === e_wd, tag, "mem_wdata", AW'(mem_wdata_o), AW'(e_wd));
    end
    chk(busy_o === m_busy, tag, "busy", AW'(busy_o), AW'(m_busy));
    chk(rd_we_o === m_ldp, tag, "rd_we", AW'(rd_we_o), AW'(m_ldp));
    if (m_ldp) chk(rd_data_o === m_ldv, tag, "rd_data", AW'(rd_data_o), AW'(m_ldv));
    chk(ptr_x_o === m_ptr[0], tag, "ptr_x", ptr_x_o, m_ptr[0]);
    chk(ptr_y_o === m_ptr[1], tag, "ptr_y", ptr_y_o, m_ptr[1]);
    chk(ptr_z_o === m_ptr[2], tag, "ptr_z", ptr_z_o, m_ptr[2]);
    chk(sp_o === m_ptr[3], tag, "sp", sp_o, m_ptr[3]);
    @(posedge clk_i);
    m_ldp = 0;
    if (e_en) begin
      if (e_we) mmem[e_addr] = e_wd;
      else begin m_ldp = 1; m_ldv = mmem[e_addr]; end
    end
    if (ptr_we_i) m_ptr[ptr_wsel_i] = ptr_wdata_i;
    if (upd) m_ptr[usel] = uval;
    if (m_busy) m_busy = 0;
    else if (two) begin m_busy = 1; m_addr = e_addr; m_we = e_we; m_wd = e_wd; end
    @(negedge clk_i);
  endtask

  task automatic drv(input logic [2:0] m, input logic [1:0] s, input logic st,
                     input logic [QW-1:0] q, input logic [AW-1:0] a, input logic [DW-1:0] d);
    req_i = 1; mode_i = m; ptr_sel_i = s; store_i = st; disp_i = q; dir_addr_i = a; wdata_i = d;
  endtask

  task automatic idle(); req_i = 0; ptr_we_i = 0; endtask

  task automatic op1(input string tag, input logic [2:0] m, input logic [1:0] s, input logic st,
                     input logic [QW-1:0] q, input logic [AW-1:0] a, input logic [DW-1:0] d);
    drv(m, s, st, q, a, d); step(tag); idle(); step(tag); step(tag);
  endtask

  task automatic ld_ptr(input logic [1:0] s, input logic [AW-1:0] v);
    ptr_we_i = 1; ptr_wsel_i = s; ptr_wdata_i = v; step("R2"); ptr_we_i = 0;
  endtask

  bit done = 0;

  initial begin
    for (int i = 0; i < 65536; i++) begin
      dmem[i] = 8'(i) ^ 8'(i >> 8) ^ 8'h5A;
      mmem[i] = dmem[i];
    end
    for (int i = 0; i < 4; i++) m_ptr[i] = '0;
    @(negedge clk_i); @(negedge clk_i);
    // R1 reset state
    chk(!busy_o && !mem_en_o && !rd_we_o, "R1", "reset ctl", AW'({busy_o, mem_en_o, rd_we_o}), 0);
    chk(ptr_x_o == 0 && sp_o == 0, "R1", "reset ptr", ptr_x_o | sp_o, 0);
    rst_ni = 1;
    step("R1"); step("R1");
    ld_ptr(0, 16'h1000); ld_ptr(1, 16'h2000); ld_ptr(2, 16'hFFFF); ld_ptr(3, 16'h30FF);
    op1("R3", 0, 0, 0, 0, 0, 0);            // load via X
    op1("R3", 0, 1, 1, 0, 0, 8'hA5);        // store via Y
    op1("R4", 1, 2, 0, 0, 0, 0);            // Z post-inc wraps to 0
    drv(1, 0, 1, 0, 0, 8'h11); step("R4"); drv(1, 0, 1, 0, 0, 8'h22); step("R4");
    drv(1, 0, 0, 0, 0, 0);     step("R10"); idle(); step("R10");
    ld_ptr(0, 16'h1000);
    drv(1, 0, 0, 0, 0, 0); step("R10"); drv(1, 0, 0, 0, 0, 0); step("R10"); idle(); step("R10");
    op1("R5", 2, 1, 0, 0, 0, 0);            // Y pre-dec load
    op1("R5", 2, 2, 1, 0, 0, 8'h3C);        // Z 0 -> FFFF store
    op1("R6", 3, 1, 0, 6'd63, 0, 0);
    op1("R6", 3, 2, 1, 6'd5, 0, 8'h77);
    op1("R6", 3, 0, 0, 6'd9, 0, 0);         // X dropped
    op1("R7", 4, 0, 0, 0, 16'h1234, 8'hC3);
    ld_ptr(0, 16'h1234);
    op1("R10", 0, 0, 0, 0, 0, 0);           // read back direct store
    op1("R8", 5, 0, 0, 0, 0, 8'h9E);
    op1("R8", 5, 0, 0, 0, 0, 8'h4B);
    op1("R9", 6, 0, 0, 0, 0, 0);
    op1("R9", 6, 0, 0, 0, 0, 0);
    ld_ptr(3, 16'hFFFF);
    op1("R9", 6, 0, 0, 0, 0, 0);            // SP wraps to 0
    ld_ptr(0, 16'h0000);
    op1("R5", 2, 0, 0, 0, 0, 0);            // X 0 -> FFFF
    // R11: request held during busy cycle
    drv(2, 0, 0, 0, 0, 0); step("R11");
    drv(1, 0, 1, 0, 0, 8'h55); step("R11");
    idle(); step("R11"); step("R11");
    // R12 ignored requests
    op1("R12", 0, 3, 1, 0, 0, 8'hEE);
    op1("R12", 1, 3, 0, 0, 0, 0);
    op1("R12", 7, 1, 1, 0, 0, 8'hEE);
    // R2 collision: op update wins over pointer load
    ptr_we_i = 1; ptr_wsel_i = 0; ptr_wdata_i = 16'hBEEF;
    drv(1, 0, 0, 0, 0, 0); step("R2");
    idle(); step("R2"); step("R2");
    ld_ptr(2, 16'h4000); step("R2");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule